// File: doc/BRIEF.md
# Maximal-Length Pseudo-Random Sequence Generator

This block is a shift register with exclusive-OR feedback that walks through every non-zero state of its width before the sequence repeats. It is built at design time for a width of 4, 8, 16 or 32 bits. Each width has its own fixed set of feedback taps, and every such set gives a maximal-length sequence. The block serves as a cheap source of pseudo-random words or bits, for example for test pattern generation or noise injection.

The register advances by one state on each clock edge where the advance input is high. A load strobe replaces the state with a caller-supplied seed, and load wins over advance. The all-zero word would lock the register forever, so the block never holds it. Reset presets every stage to one, and a zero seed is replaced by the all-ones word. The full parallel state is available as an output, and so is a serial bit that carries the highest stage.

Top module: `prng_lfsr_gen`

## Requirements
- R1: A synchronous active-high reset sets the state to all ones and the serial output to 1 at the next edge.
- R2: With advance high and load low, each stage k (1-indexed, stage 1 at bit 0) takes the old value of stage k-1. Stage 1 takes the XOR of the tap stages. The taps are {4,3} for width 4, {8,6,5,4} for width 8, {16,15,13,4} for width 16 and {32,22,2,1} for width 32.
- R3: With advance low and load low, the state and the serial output do not change.
- R4: With load high and a non-zero seed, the state becomes the seed at the next edge, whatever the advance input is.
- R5: With load high and a seed of zero, the state becomes all ones.
- R6: When load and advance are both high, the load takes effect and no shift happens.
- R7: The serial output always equals the highest stage of the state output (bit WIDTH-1).
- R8: At width 4, starting from 0001 (stage 4 down to stage 1), successive advances give 0010, 0100, 1001, 0011, 0110, 1101, 1010, 0101, 1011, 0111, 1111, 1110, 1100, 1000, and the next advance gives 0001 again.
- R9: At width N, continuous advancing visits each of the 2^N-1 non-zero states exactly once per period, then returns to the starting state.
- R10: After reset, the state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset, presets all ones |
| adv | input | 1 | Advance the sequence by one state |
| load | input | 1 | Load the seed; takes priority over adv |
| seed | input | WIDTH | Seed word; zero is replaced by all ones |
| state_o | output | WIDTH | Registered parallel state, bit 0 is stage 1 |
| serial_o | output | 1 | Registered copy of the highest stage |

## Verification
The assertions assume that reset is applied for at least one edge before any check counts. They also assume that adv, load and seed carry known values on every edge after that, and that WIDTH is one of the four supported values. The stimulus starts with reset and drives every control and seed to a defined level one time unit after each rising edge. It only instantiates the four supported widths, so each property sees a defined previous cycle. The sequence checks need no model of the feedback in the case of widths 4 and 8. Width 4 is compared with the listed sequence. Width 8 is checked for a full period with no repeated state.

// File: rtl/lfsr_gen_pkg.sv
package lfsr_gen_pkg;

  // Feedback tap mask for a supported width; bit i set means stage i+1 is a tap.
  function automatic logic [31:0] tap_mask(input int unsigned w);
    logic [31:0] m;
    case (w)
      4:       m = (32'd1 << 3) | (32'd1 << 2);
      8:       m = (32'd1 << 7) | (32'd1 << 5) | (32'd1 << 4) | (32'd1 << 3);
      16:      m = (32'd1 << 15) | (32'd1 << 14) | (32'd1 << 12) | (32'd1 << 3);
      32:      m = (32'd1 << 31) | (32'd1 << 21) | (32'd1 << 1) | (32'd1 << 0);
      default: m = 32'd0;
    endcase
    return m;
  endfunction

  typedef enum logic [1:0] {
    NXT_HOLD = 2'd0,
    NXT_SHIFT = 2'd1,
    NXT_LOAD = 2'd2
  } nxt_kind_e;

endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);
  localparam logic [31:0] MASK = lfsr_gen_pkg::tap_mask(WIDTH);

  // Gate each stage by its tap bit, then fold with a parity reduction.
  logic [WIDTH-1:0] gated;
  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (MASK[i]) begin : g_on
      assign gated[i] = state[i];
    end else begin : g_off
      assign gated[i] = 1'b0;
    end
  end

  assign fb = ^gated;
endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] seed_safe
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  always_comb begin
    if (seed == '0) seed_safe = ALL_ONES;
    else            seed_safe = seed;
  end
endmodule

// File: rtl/lfsr_next_sel.sv
module lfsr_next_sel #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] state,
  input  logic             fb,
  input  logic [WIDTH-1:0] seed_safe,
  input  logic             adv,
  input  logic             load,
  output logic [WIDTH-1:0] nxt,
  output logic             upd
);
  import lfsr_gen_pkg::*;

  nxt_kind_e kind;

  always_comb begin
    if (load)     kind = NXT_LOAD;
    else if (adv) kind = NXT_SHIFT;
    else          kind = NXT_HOLD;
  end

  always_comb begin
    unique case (kind)
      NXT_LOAD:  nxt = seed_safe;
      NXT_SHIFT: nxt = {state[WIDTH-2:0], fb};
      default:   nxt = state;
    endcase
    upd = (kind != NXT_HOLD);
  end
endmodule

// File: rtl/prng_lfsr_gen.sv
module prng_lfsr_gen #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state_o,
  output logic             serial_o
);
  localparam logic [WIDTH-1:0] PRESET = {WIDTH{1'b1}};

  logic [WIDTH-1:0] state_q;
  logic             serial_q;
  logic             fb;
  logic [WIDTH-1:0] seed_safe;
  logic [WIDTH-1:0] nxt;
  logic             upd;

  lfsr_feedback #(.WIDTH(WIDTH)) u_fb (
    .state (state_q),
    .fb    (fb)
  );

  lfsr_seed_guard #(.WIDTH(WIDTH)) u_guard (
    .seed      (seed),
    .seed_safe (seed_safe)
  );

  lfsr_next_sel #(.WIDTH(WIDTH)) u_sel (
    .state     (state_q),
    .fb        (fb),
    .seed_safe (seed_safe),
    .adv       (adv),
    .load      (load),
    .nxt       (nxt),
    .upd       (upd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PRESET;
      serial_q <= 1'b1;
    end else if (upd) begin
      state_q  <= nxt;
      serial_q <= nxt[WIDTH-1];
    end
  end

  assign state_o  = state_q;
  assign serial_o = serial_q;
endmodule

// File: rtl/lfsr_gen_chk.sv
module lfsr_gen_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             adv,
  input logic             load,
  input logic [WIDTH-1:0] seed,
  input logic [WIDTH-1:0] state_o,
  input logic             serial_o
);
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  logic armed = 1'b0;
  logic prev_rst = 1'b0;

  always_ff @(posedge clk) begin
    armed    <= armed | rst;
    prev_rst <= rst;
  end

  AST_RESET_PRESET: assert property (@(posedge clk) disable iff (rst)
    (armed && prev_rst) |-> (state_o == ONES && serial_o)); // R1

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
    (armed && !prev_rst && $past(adv) && !$past(load))
      |-> (state_o[WIDTH-1:1] == $past(state_o[WIDTH-2:0]))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (armed && !prev_rst && !$past(adv) && !$past(load))
      |-> ($stable(state_o) && $stable(serial_o))); // R3

  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (rst)
    (armed && !prev_rst && $past(load) && $past(seed) != '0)
      |-> (state_o == $past(seed))); // R4

  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (rst)
    (armed && !prev_rst && $past(load) && $past(seed) == '0)
      |-> (state_o == ONES)); // R5

  AST_SERIAL_MSB: assert property (@(posedge clk) disable iff (rst)
    armed |-> (serial_o == state_o[WIDTH-1])); // R7

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    armed |-> (state_o != '0)); // R10
endmodule

bind prng_lfsr_gen lfsr_gen_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .adv      (adv),
  .load     (load),
  .seed     (seed),
  .state_o  (state_o),
  .serial_o (serial_o)
);

// File: tb/test_prng_lfsr_gen.sv
module test_prng_lfsr_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b0;
  logic load = 1'b0;
  logic [3:0]  seed4 = '0;
  logic [7:0]  seed8 = '0;
  logic [15:0] seed16 = '0;
  logic [31:0] seed32 = '0;
  logic [3:0]  st4;
  logic [7:0]  st8;
  logic [15:0] st16;
  logic [31:0] st32;
  logic ser4, ser8, ser16, ser32;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prng_lfsr_gen #(.WIDTH(4)) i_prng_lfsr_gen (
    .clk(clk), .rst(rst), .adv(adv), .load(load), .seed(seed4),
    .state_o(st4), .serial_o(ser4));
  prng_lfsr_gen #(.WIDTH(8)) i_prng_lfsr_gen_w8 (
    .clk(clk), .rst(rst), .adv(adv), .load(load), .seed(seed8),
    .state_o(st8), .serial_o(ser8));
  prng_lfsr_gen #(.WIDTH(16)) i_prng_lfsr_gen_w16 (
    .clk(clk), .rst(rst), .adv(adv), .load(load), .seed(seed16),
    .state_o(st16), .serial_o(ser16));
  prng_lfsr_gen #(.WIDTH(32)) i_prng_lfsr_gen_w32 (
    .clk(clk), .rst(rst), .adv(adv), .load(load), .seed(seed32),
    .state_o(st32), .serial_o(ser32));

  // Width-4 sequence from R8, index = advances since state 0001.
  localparam logic [3:0] SEQ4 [15] = '{4'h1, 4'h2, 4'h4, 4'h9, 4'h3, 4'h6, 4'hD,
                                       4'hA, 4'h5, 4'hB, 4'h7, 4'hF, 4'hE, 4'hC, 4'h8};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_serial(input string req);
    chk(ser4 == st4[3], req, {31'd0, ser4}, {31'd0, st4[3]});
    chk(ser8 == st8[7], req, {31'd0, ser8}, {31'd0, st8[7]});
    chk(ser16 == st16[15], req, {31'd0, ser16}, {31'd0, st16[15]});
    chk(ser32 == st32[31], req, {31'd0, ser32}, {31'd0, st32[31]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit visited8 [256];
    logic [7:0]  p8;
    logic [15:0] p16;
    logic [31:0] p32;
    logic [3:0]  h4;
    logic [7:0]  h8;

    // R1: reset preset
    tick(); tick();
    rst = 1'b0;
    chk(st4 == 4'hF, "R1 w4 preset", {28'd0, st4}, 32'hF);
    chk(st8 == 8'hFF, "R1 w8 preset", {24'd0, st8}, 32'hFF);
    chk(st16 == 16'hFFFF, "R1 w16 preset", {16'd0, st16}, 32'hFFFF);
    chk(st32 == 32'hFFFF_FFFF, "R1 w32 preset", st32, 32'hFFFF_FFFF);
    chk_serial("R7 after reset");

    // R4/R6: load seed 1 with advance also high
    seed4 = 4'h1; seed8 = 8'h01; seed16 = 16'h0001; seed32 = 32'h1;
    load = 1'b1; adv = 1'b1;
    tick();
    load = 1'b0;
    chk(st4 == 4'h1, "R6 w4 load beats adv", {28'd0, st4}, 32'h1);
    chk(st8 == 8'h01, "R4 w8 load", {24'd0, st8}, 32'h1);
    chk(st16 == 16'h1, "R4 w16 load", {16'd0, st16}, 32'h1);
    chk(st32 == 32'h1, "R4 w32 load", st32, 32'h1);
    foreach (visited8[i]) visited8[i] = 1'b0;
    visited8[1] = 1'b1;

    // R2, R8, R9, R10: run one full width-8 period
    for (int k = 1; k <= 255; k++) begin
      p8 = st8; p16 = st16; p32 = st32;
      tick();
      chk(st4 == SEQ4[k % 15], "R8 w4 sequence", {28'd0, st4}, {28'd0, SEQ4[k % 15]});
      chk(st8 != 8'h00, "R10 w8 nonzero", {24'd0, st8}, 32'h1);
      chk(st8[7:1] == p8[6:0], "R2 w8 shift", {25'd0, st8[7:1]}, {25'd0, p8[6:0]});
      if (k < 255) begin
        chk(!visited8[st8], "R9 w8 state unique", {24'd0, st8}, 32'h0);
        visited8[st8] = 1'b1;
      end else begin
        chk(st8 == 8'h01, "R9 w8 period 255", {24'd0, st8}, 32'h1);
      end
      chk(st16 == {p16[14:0], p16[15] ^ p16[14] ^ p16[12] ^ p16[3]},
          "R2 w16 taps", {16'd0, st16},
          {16'd0, p16[14:0], p16[15] ^ p16[14] ^ p16[12] ^ p16[3]});
      chk(st32 == {p32[30:0], p32[31] ^ p32[21] ^ p32[1] ^ p32[0]},
          "R2 w32 taps", st32, {p32[30:0], p32[31] ^ p32[21] ^ p32[1] ^ p32[0]});
      chk(st16 != 16'h0, "R10 w16 nonzero", {16'd0, st16}, 32'h1);
      chk_serial("R7 during run");
    end
    // 255 = 17 * 15, so the width-4 register is back at 0001
    chk(st4 == 4'h1, "R8 w4 returns to 0001", {28'd0, st4}, 32'h1);

    // R3: hold with advance low
    adv = 1'b0;
    h4 = st4; h8 = st8;
    for (int k = 0; k < 3; k++) begin
      seed4 = 4'h0; seed8 = 8'h00;
      tick();
      chk(st4 == h4, "R3 w4 hold", {28'd0, st4}, {28'd0, h4});
      chk(st8 == h8, "R3 w8 hold", {24'd0, st8}, {24'd0, h8});
      chk_serial("R7 during hold");
    end

    // R4: load non-zero seed with advance low
    seed4 = 4'hA; seed8 = 8'h5A; load = 1'b1;
    tick();
    chk(st4 == 4'hA, "R4 w4 load adv low", {28'd0, st4}, 32'hA);
    chk(st8 == 8'h5A, "R4 w8 load adv low", {24'd0, st8}, 32'h5A);
    chk_serial("R7 after load");

    // R5: zero seed becomes all ones, also with advance high (R6)
    seed4 = 4'h0; seed8 = 8'h00; seed16 = 16'h0; seed32 = 32'h0; adv = 1'b1;
    tick();
    load = 1'b0;
    chk(st4 == 4'hF, "R5 w4 zero seed", {28'd0, st4}, 32'hF);
    chk(st8 == 8'hFF, "R5 w8 zero seed", {24'd0, st8}, 32'hFF);
    chk(st16 == 16'hFFFF, "R5 w16 zero seed", {16'd0, st16}, 32'hFFFF);
    chk(st32 == 32'hFFFF_FFFF, "R5 w32 zero seed", st32, 32'hFFFF_FFFF);

    // R2 from all ones at width 4: 1111 -> 1110 (stage 4 ^ stage 3 = 0)
    tick();
    chk(st4 == 4'hE, "R2 w4 from ones", {28'd0, st4}, 32'hE);

    // R1: reset in mid-run wins over advance
    rst = 1'b1;
    tick();
    rst = 1'b0; adv = 1'b0;
    chk(st4 == 4'hF, "R1 w4 mid-run reset", {28'd0, st4}, 32'hF);
    chk(ser4 == 1'b1, "R1 w4 serial preset", {31'd0, ser4}, 32'h1);
    chk(st8 == 8'hFF, "R1 w8 mid-run reset", {24'd0, st8}, 32'hFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule